// File: doc/BRIEF.md
# Full-Period Pseudo-Random State Generator

This block produces a pseudo-random word of `WIDTH` bits that walks through every one of the 2^WIDTH possible values exactly once per period, the all-zero word included. It is a right-shifting linear feedback shift register whose tap set is a primitive polynomial. The feedback bit is inverted whenever every state bit except the one about to be shifted out is zero. This splices the zero word into the cycle directly after the word of value one. Because no value is missing from the cycle, the state can be taken as-is, or in part, as a uniformly distributed index, for example a random virtual-channel number. No bias correction is needed.

The state moves one step on each clock where the advance enable is high. A synchronous seed load can put the generator at any point of its cycle, zero included, and takes priority over advancing. Reset is asserted asynchronously and active-low, and it is released in step with the clock through a two-stage synchronizer. The state then starts from the `RESET_VALUE` parameter.

Top module: `cfsr_gen`

## Requirements
- R1: After reset, and before any load or advance, `state_out` equals `RESET_VALUE` (default 8'h01).
- R2: On a clock where `seed_load` and `adv_en` are both low, `state_out` keeps its value.
- R3: On a clock where `seed_load` is high, `state_out` takes `seed_val` in the following cycle, whatever the value of `adv_en`.
- R4: Zero is a legal seed. After loading 0, one advance gives the word with only the MSB set (8'h80 by default).
- R5: From the state of value 1, one advance gives the all-zero state.
- R6: In all other states, an advance shifts the state right by one bit. The new MSB is the XOR of the state bits selected by `TAPS` (default 8'h71, bits 0, 4, 5 and 6, for x^8+x^6+x^5+x^4+1).
- R7: Starting from any state, 2^WIDTH consecutive advances visit every value exactly once and return to the starting value.
- R8: From the all-zero state, one advance gives the word with only the MSB set. This is the state that a plain shift register would have entered after state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adv_en | input | 1 | Step the sequence by one state on this clock |
| seed_load | input | 1 | Write `seed_val` into the state (takes priority over `adv_en`) |
| seed_val | input | WIDTH | Seed word for a load |
| state_out | output | WIDTH | Current state word |

## Verification
The hardest event to reach from the ports is the splice itself. State 1 comes up only once in 2^WIDTH advances, and the zero word only once after it, so free running would rarely reach the 1 → 0 → MSB-only chain. The stimulus jumps straight to these states. It uses the reset value of 1 for the first entry into zero, and it loads a zero seed for a second route to it. A full-period walk from a loaded seed of 1 then records every visited value, and a check confirms that each value appears once and that the walk closes on its start.

// File: rtl/cfsr_pkg.sv
package cfsr_pkg;

  localparam int MAX_WIDTH = 64;

  // Primitive feedback masks for a right-shifting register: bit i set means
  // state bit i takes part in the new MSB (polynomial term x^i).
  function automatic logic [MAX_WIDTH-1:0] default_taps(input int width);
    logic [MAX_WIDTH-1:0] m;
    m = '0;
    case (width)
      2:       m = 64'h3;
      3:       m = 64'h5;
      4:       m = 64'h9;
      5:       m = 64'h9;
      6:       m = 64'h21;
      7:       m = 64'h41;
      8:       m = 64'h71;
      16:      m = 64'hA011;
      default: m = 64'h71;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cfsr_rst_sync.sv
module cfsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/cfsr_feedback.sv
module cfsr_feedback #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'h71
) (
  input  logic [WIDTH-1:0] state_q,
  output logic             raw_fb
);
  logic [WIDTH-1:0] masked;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign masked[i] = state_q[i];
    end else begin : g_off
      assign masked[i] = 1'b0;
    end
  end

  assign raw_fb = ^masked;
endmodule

// File: rtl/cfsr_zero_splice.sv
module cfsr_zero_splice #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] state_q,
  input  logic             raw_fb,
  output logic             fb
);
  logic upper_clear;

  // All bits that survive the shift are zero: the state is 1 or 0.
  // Flipping the feedback there swaps their successors, folding 0 into the cycle.
  assign upper_clear = ~|state_q[WIDTH-1:1];
  assign fb          = raw_fb ^ upper_clear;
endmodule

// File: rtl/cfsr_gen.sv
module cfsr_gen #(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] TAPS        = WIDTH'(cfsr_pkg::default_taps(WIDTH)),
  parameter logic [WIDTH-1:0] RESET_VALUE = WIDTH'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_val,
  output logic [WIDTH-1:0] state_out
);
  localparam int KEEP = WIDTH - 1;

  logic             rst_sync_n;
  logic             raw_fb;
  logic             fb;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             state_en;

  cfsr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfsr_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_feedback (
    .state_q (state_q),
    .raw_fb  (raw_fb)
  );

  cfsr_zero_splice #(.WIDTH(WIDTH)) u_splice (
    .state_q (state_q),
    .raw_fb  (raw_fb),
    .fb      (fb)
  );

  always_comb begin
    state_en = seed_load | adv_en;
    if (seed_load) state_d = seed_val;
    else           state_d = {fb, state_q[WIDTH-1:WIDTH-KEEP]};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   state_q <= RESET_VALUE;
    else if (state_en) state_q <= state_d;
  end

  assign state_out = state_q;
endmodule

// File: rtl/cfsr_gen_chk.sv
module cfsr_gen_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             adv_en,
  input logic             seed_load,
  input logic [WIDTH-1:0] seed_val,
  input logic [WIDTH-1:0] state_q
);
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (!seed_load && !adv_en) |=> $stable(state_q));

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_ok)
    seed_load |=> (state_q == $past(seed_val)));

  a_r5_one_to_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    (adv_en && !seed_load && state_q == ONE) |=> (state_q == '0));

  a_r8_zero_exit: assert property (@(posedge clk) disable iff (!rst_ok)
    (adv_en && !seed_load && state_q == '0) |=> (state_q == MSB_ONLY));

  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_ok)
    (adv_en && !seed_load) |=> (state_q[WIDTH-2:0] == $past(state_q[WIDTH-1:1])));
endmodule

bind cfsr_gen cfsr_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .adv_en    (adv_en),
  .seed_load (seed_load),
  .seed_val  (seed_val),
  .state_q   (state_out)
);

// File: tb/cfsr_gen_bench.sv
`timescale 1ns/1ps
module cfsr_gen_bench;
  localparam int         W     = 8;
  localparam int         NVAL  = 1 << W;
  localparam logic [W-1:0] MASK = 8'h71;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         adv_en;
  logic         seed_load;
  logic [W-1:0] seed_val;
  logic [W-1:0] state_out;

  int checks   = 0;
  int failures = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] model;
  int           seen [NVAL];

  always #2.5 clk = ~clk;

  cfsr_gen u_cfsr_gen (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en),
    .seed_load(seed_load), .seed_val(seed_val), .state_out(state_out)
  );

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] s);
    logic f;
    f = ^(s & MASK);
    if (s[W-1:1] == '0) f = ~f;       // R5 / R8 splice
    return {f, s[W-1:1]};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one call per clock; pushes the value expected after the next edge.
  task automatic step(input logic adv, input logic ld, input logic [W-1:0] sd,
                      input string req, output logic [W-1:0] cur);
    @(negedge clk);
    cur       = state_out;
    adv_en    = adv;
    seed_load = ld;
    seed_val  = sd;
    if (ld)       model = sd;
    else if (adv) model = ref_next(model);
    exp_q.push_back(model);
    tag_q.push_back(req);
  endtask

  // Monitor: compares after each edge, away from both clock edges.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), state_out, exp_q.pop_front());
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] c;
    rst_n = 1'b0; adv_en = 1'b0; seed_load = 1'b0; seed_val = '0;
    model = 8'h01;
    repeat (3) @(negedge clk);
    check("R1", state_out, 8'h01);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 8'hFF, "R2", c);  // also covers sync release
    check("R1", state_out, 8'h01);
    step(1'b1, 1'b0, '0, "R5", c);      // 1 -> 0
    step(1'b1, 1'b0, '0, "R8", c);      // 0 -> 80
    step(1'b0, 1'b0, 8'h33, "R2", c);
    step(1'b1, 1'b1, 8'hA5, "R3", c);   // load wins over advance
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, '0, "R6", c);
    step(1'b0, 1'b1, 8'h00, "R4", c);
    step(1'b1, 1'b0, '0, "R4", c);      // 0 -> 80
    step(1'b0, 1'b0, '0, "R2", c);
    step(1'b0, 1'b1, 8'h01, "R3", c);
    for (int v = 0; v < NVAL; v++) seen[v] = 0;
    for (int i = 0; i < NVAL; i++) begin
      step(1'b1, 1'b0, '0, "R7", c);
      if (i > 0) seen[c]++;
    end
    step(1'b0, 1'b0, '0, "R7", c);
    seen[c]++;
    check("R7", c, 8'h01);              // cycle closes on its start
    begin
      int bad = 0;
      for (int v = 0; v < NVAL; v++) if (seen[v] != 1) bad++;
      checks++;
      if (bad != 0) begin
        failures++;
        $display("FAIL R7 actual=%0d values not seen once expected=0", bad);
      end
    end
    step(1'b0, 1'b0, '0, "R2", c);
    while (exp_q.size() > 0) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule